// File: doc/BRIEF.md
# Serial EEPROM Command Controller

This block sits between host software and a byte-wide serial EEPROM. Software sees two registers on a small CSR bus. The command word carries a start/busy flag, an operation code and a 9-bit byte address, so 512 bytes can be addressed. The data word carries the byte that is fetched or stored. Software loads the command with the start flag set. The controller then carries out the operation and drops the flag when the operation ends, and software polls the flag to learn the result.

Requests toward the storage pass through a request/acknowledge port. Writes to storage are refused until a write/erase-enable operation has been run, and the enable then stays set until reset. If the storage never acknowledges, an internal cycle counter ends the operation after a fixed limit. It raises a sticky timeout flag that software can read.

Top module: `eep_cmd_ctrl`

## Requirements
- R1: After reset the command word (offset 0x040) and the data word (offset 0x044) both read 0, `mem_req` is low and write-enable is clear.
- R2: Command word layout: bit 31 is busy, bits 30:28 are the opcode, bit 10 is the timeout flag and bits 8:0 are the byte address. Every other bit reads 0. An offset that matches neither register reads 0.
- R3: A command write with bit 31 set, made while idle, launches the command, and busy reads 1 from the next cycle. A command write with bit 31 clear has no effect.
- R4: Opcode 0 (read) holds `mem_req` with `mem_we` low at the given address. In the cycle the acknowledge is sampled, `mem_rdata` is stored into data bits 7:0 and busy clears, so busy lasts the memory latency plus one cycle.
- R5: Opcode 2 (write/erase enable) stays busy for one cycle and issues no memory request. It latches write-enable, which holds until reset.
- R6: Opcode 3 (write), once write-enable is latched, requests a memory write of data bits 7:0 to the address. A write without enable, or opcodes 1 and 4 to 7, stays busy for one cycle and touches no memory.
- R7: Data-word writes keep only bits 7:0, and bits 31:8 always read 0.
- R8: While busy, writes to the command word and to the data word are ignored.
- R9: If no acknowledge arrives, the request ends after exactly TIMEOUT_CYCLES busy cycles. The timeout flag sets, busy clears, `mem_req` drops and the data word is unchanged.
- R10: The timeout flag stays set until the next command launch, which clears it.
- R11: While a request is pending and neither acknowledged nor timed out, `mem_req`, `mem_addr`, `mem_we` and `mem_wdata` stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_addr | input | CSR_AW | CSR byte offset |
| csr_wr | input | 1 | CSR write strobe |
| csr_wdata | input | 32 | CSR write data |
| csr_rdata | output | 32 | CSR read data, combinational from `csr_addr` |
| mem_req | output | 1 | Storage request, held until acknowledged or timed out |
| mem_we | output | 1 | 1 for a store, 0 for a fetch |
| mem_addr | output | 9 | Storage byte address |
| mem_wdata | output | 8 | Byte to store |
| mem_rdata | input | 8 | Fetched byte, valid with `mem_ack` |
| mem_ack | input | 1 | Storage acknowledge |

## Verification
The assertions assume that the storage raises `mem_ack` only while `mem_req` is high, and that `mem_rdata` is valid in the same cycle as the acknowledge. The bench's storage model keeps to this rule. It counts the cycles of a pending request, drives the acknowledge one negative edge before the chosen latency runs out, and drops it as soon as the request goes away. The model can also hold off the acknowledge for good, which drives the timeout path. Host accesses are single-cycle strobes that the bench drives on negative edges.

// File: rtl/eep_pkg.sv
package eep_pkg;
  localparam int ADDR_W  = 9;
  localparam int BUSY_B  = 31;
  localparam int OP_LSB  = 28;
  localparam int TMO_B   = 10;

  localparam logic [2:0] OP_READ  = 3'd0;
  localparam logic [2:0] OP_EWEN  = 3'd2;
  localparam logic [2:0] OP_WRITE = 3'd3;

  // Assemble the command word as software reads it
  function automatic logic [31:0] pack_cmd(input logic busy, input logic [2:0] op,
                                           input logic tmo, input logic [ADDR_W-1:0] a);
    logic [31:0] w;
    w = '0;
    w[BUSY_B] = busy;
    w[OP_LSB +: 3] = op;
    w[TMO_B] = tmo;
    w[ADDR_W-1:0] = a;
    return w;
  endfunction

  // An operation reaches the storage only for a read, or for a write once enabled
  function automatic logic touches_memory(input logic [2:0] op, input logic wen);
    return (op == OP_READ) || ((op == OP_WRITE) && wen);
  endfunction
endpackage

// File: rtl/eep_cmd_decode.sv
module eep_cmd_decode
  import eep_pkg::*;
(
  input  logic [31:0]       wdata,
  input  logic              wen,
  output logic              go,
  output logic [2:0]        op,
  output logic [ADDR_W-1:0] addr,
  output logic              mem_op
);
  logic unused_bits;
  assign unused_bits = ^wdata[27:ADDR_W];
  assign go     = wdata[BUSY_B];
  assign op     = wdata[OP_LSB +: 3];
  assign addr   = wdata[ADDR_W-1:0];
  assign mem_op = touches_memory(op, wen);
endmodule

// File: rtl/eep_ack_timer.sv
module eep_ack_timer #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic waiting,
  output logic expire
);
  localparam int CW = (LIMIT < 2) ? 1 : $clog2(LIMIT);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  assign expire = waiting && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (!waiting || expire) cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end

  // R9
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
endmodule

// File: rtl/eep_cmd_ctrl.sv
module eep_cmd_ctrl
  import eep_pkg::*;
#(
  parameter int          CSR_AW         = 12,
  parameter int          TIMEOUT_CYCLES = 16,
  parameter logic [11:0] CMD_OFS        = 12'h040,
  parameter logic [11:0] DATA_OFS       = 12'h044
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CSR_AW-1:0] csr_addr,
  input  logic              csr_wr,
  input  logic [31:0]       csr_wdata,
  output logic [31:0]       csr_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [8:0]        mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata,
  input  logic              mem_ack
);
  localparam logic [CSR_AW-1:0] CMD_A  = CSR_AW'(CMD_OFS);
  localparam logic [CSR_AW-1:0] DATA_A = CSR_AW'(DATA_OFS);

  logic              busy_q, tmo_q, wen_q, memop_q;
  logic [2:0]        op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        data_q;

  // Named internal events
  logic              cmd_wr, data_wr, launch, mem_done, rd_done, local_done, expire, finish;
  logic              dec_go, dec_mem;
  logic [2:0]        dec_op;
  logic [ADDR_W-1:0] dec_addr;
  logic              unused_data;

  eep_cmd_decode u_dec (
    .wdata (csr_wdata),
    .wen   (wen_q),
    .go    (dec_go),
    .op    (dec_op),
    .addr  (dec_addr),
    .mem_op(dec_mem)
  );

  assign cmd_wr     = csr_wr && (csr_addr == CMD_A);
  assign data_wr    = csr_wr && (csr_addr == DATA_A) && !busy_q;
  assign launch     = cmd_wr && !busy_q && dec_go;
  assign mem_req    = busy_q && memop_q;
  assign mem_done   = mem_req && mem_ack;
  assign rd_done    = mem_done && !mem_we;
  assign local_done = busy_q && !memop_q;
  assign finish     = mem_done || local_done || expire;
  assign unused_data = ^csr_wdata[31:8];

  eep_ack_timer #(.LIMIT(TIMEOUT_CYCLES)) u_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .waiting(mem_req && !mem_ack),
    .expire (expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      tmo_q   <= 1'b0;
      wen_q   <= 1'b0;
      memop_q <= 1'b0;
      op_q    <= '0;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      if (launch) begin
        busy_q  <= 1'b1;
        tmo_q   <= 1'b0;
        memop_q <= dec_mem;
        op_q    <= dec_op;
        addr_q  <= dec_addr;
      end else if (finish) begin
        busy_q  <= 1'b0;
        memop_q <= 1'b0;
        if (expire) tmo_q <= 1'b1;
        if (local_done && op_q == OP_EWEN) wen_q <= 1'b1;
      end
      if (rd_done)      data_q <= mem_rdata;
      else if (data_wr) data_q <= csr_wdata[7:0];
    end
  end

  assign mem_we    = (op_q == OP_WRITE);
  assign mem_addr  = addr_q;
  assign mem_wdata = data_q;

  always_comb begin
    if (csr_addr == CMD_A)       csr_rdata = pack_cmd(busy_q, op_q, tmo_q, addr_q);
    else if (csr_addr == DATA_A) csr_rdata = {24'd0, data_q};
    else                         csr_rdata = '0;
  end

  // R4
  read_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |=> (data_q == $past(mem_rdata)) && !busy_q);
  // R5
  ewen_no_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && op_q == OP_EWEN) |-> !mem_req);
  // R6
  no_write_without_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> wen_q);
  // R8
  ignore_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cmd_wr) |=> $stable(op_q) && $stable(addr_q));
  // R9
  expire_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> !busy_q && tmo_q && !mem_req);
  // R10
  tmo_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_q && !launch) |=> tmo_q);
  // R11
  req_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack && !expire) |=> mem_req && $stable(mem_addr)
      && $stable(mem_we) && $stable(mem_wdata));
endmodule

// File: tb/test_eep_cmd_ctrl.sv
module test_eep_cmd_ctrl;
  localparam int          LIMIT = 16;
  localparam logic [11:0] CMD   = 12'h040;
  localparam logic [11:0] DAT   = 12'h044;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] csr_addr = '0;
  logic        csr_wr = 1'b0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  logic        mem_req, mem_we;
  logic [8:0]  mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = '0;
  logic        mem_ack = 1'b0;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  eep_cmd_ctrl i_eep_cmd_ctrl (
    .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_wr(csr_wr),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  // Storage model
  logic [7:0] store [512];
  int lat = 0;
  int waitc = 0;
  bit stall = 0;
  int wr_cnt = 0;

  always @(negedge clk) begin
    if (mem_ack) mem_ack = 1'b0;
    else if (mem_req) begin
      if (waitc >= lat && !stall) begin
        mem_ack = 1'b1;
        if (mem_we) begin store[mem_addr] = mem_wdata; wr_cnt++; end
        else mem_rdata = store[mem_addr];
        waitc = 0;
      end else waitc++;
    end else waitc = 0;
  end

  // Scoreboard queue of expected data-word bytes
  logic [7:0] exp_q[$];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic csr_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    csr_addr = a; csr_wdata = d; csr_wr = 1'b1;
    @(posedge clk);
    #1 csr_wr = 1'b0;
  endtask

  task automatic csr_read(input logic [11:0] a, output logic [31:0] v);
    @(negedge clk);
    csr_addr = a;
    #1 v = csr_rdata;
  endtask

  task automatic issue(input logic go, input logic [2:0] op, input logic [8:0] a);
    csr_write(CMD, {go, op, 19'd0, a});
  endtask

  task automatic wait_idle(output int cyc);
    cyc = 0;
    csr_addr = CMD;
    for (int k = 0; k < 1000; k++) begin
      @(negedge clk);
      #1;
      if (!csr_rdata[31]) break;
      cyc++;
    end
  endtask

  // Driver: push expected byte, run the read
  task automatic sb_read(input logic [8:0] a, input int l, output int cyc);
    exp_q.push_back(store[a]);
    lat = l;
    issue(1'b1, 3'd0, a);
    wait_idle(cyc);
  endtask

  // Monitor: pop expected byte and compare with the data word
  task automatic sb_check(input string req);
    logic [31:0] v;
    logic [7:0] e;
    csr_read(DAT, v);
    e = exp_q.pop_front();
    chk(req, v, {24'd0, e});
  endtask

  initial begin
    int c;
    logic [31:0] v;
    int w0;
    for (int i = 0; i < 512; i++) store[i] = 8'((i * 7 + 3) & 255);
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    csr_read(CMD, v); chk("R1 cmd", v, 32'h0);
    csr_read(DAT, v); chk("R1 data", v, 32'h0);
    chk("R1 mem_req", {31'd0, mem_req}, 32'h0);
    csr_read(12'h048, v); chk("R2 unmapped", v, 32'h0);

    // R4 read, zero latency
    sb_read(9'd5, 0, c); chk("R4 busy cycles lat0", c, 1); sb_check("R4 data addr5");
    // R4 read at top address, latency 3
    sb_read(9'd511, 3, c); chk("R4 busy cycles lat3", c, 4); sb_check("R4 data addr511");
    csr_read(CMD, v); chk("R2 cmd layout", v, 32'h0000_01FF);

    // R7 data word keeps low byte only
    csr_write(DAT, 32'hABCD_EF12);
    csr_read(DAT, v); chk("R7 data upper zero", v, 32'h12);

    // R6 write without enable
    w0 = wr_cnt;
    issue(1'b1, 3'd3, 9'd7); wait_idle(c);
    chk("R6 no-enable busy", c, 1);
    chk("R6 no-enable no store", wr_cnt, w0);
    sb_read(9'd7, 0, c); sb_check("R6 addr7 unchanged");

    // R6 undefined opcode
    issue(1'b1, 3'd5, 9'd8); wait_idle(c);
    chk("R6 opcode5 busy", c, 1);
    csr_read(CMD, v); chk("R2 opcode5 layout", v, 32'h5000_0008);

    // R5 enable
    issue(1'b1, 3'd2, 9'd0); wait_idle(c);
    chk("R5 enable busy", c, 1);
    chk("R5 enable no store", wr_cnt, w0);

    // R6 enabled write
    csr_write(DAT, 32'h3C);
    lat = 2;
    issue(1'b1, 3'd3, 9'd7); wait_idle(c);
    chk("R6 write busy", c, 3);
    chk("R6 write count", wr_cnt, w0 + 1);
    chk("R6 stored byte", {24'd0, store[7]}, 32'h3C);
    sb_read(9'd7, 1, c); sb_check("R6 readback addr7");

    // R5 enable still latched after other commands
    csr_write(DAT, 32'hC3);
    issue(1'b1, 3'd3, 9'd0); wait_idle(c);
    chk("R5 latched store", {24'd0, store[0]}, 32'hC3);

    // R8 writes ignored while busy
    exp_q.push_back(store[9]);
    lat = 4;
    issue(1'b1, 3'd0, 9'd9);
    issue(1'b1, 3'd0, 9'd20);
    csr_write(DAT, 32'h77);
    wait_idle(c);
    sb_check("R8 data from first command");
    csr_read(CMD, v); chk("R8 cmd unchanged", v, 32'h0000_0009);

    // R3 write without start flag
    issue(1'b0, 3'd0, 9'd33);
    csr_read(CMD, v); chk("R3 no launch", v, 32'h0000_0009);

    // R9 timeout
    stall = 1;
    issue(1'b1, 3'd0, 9'd4); wait_idle(c);
    chk("R9 busy cycles", c, LIMIT);
    csr_read(CMD, v); chk("R9 timeout flag", v, 32'h0000_0404);
    chk("R9 req dropped", {31'd0, mem_req}, 32'h0);
    csr_read(DAT, v); chk("R9 data unchanged", v, {24'd0, store[9]});
    stall = 0;

    // R10 sticky then cleared by launch
    csr_write(DAT, 32'h11);
    csr_read(CMD, v); chk("R10 sticky", v, 32'h0000_0404);
    exp_q.push_back(store[6]);
    lat = 3;
    issue(1'b1, 3'd0, 9'd6);
    csr_read(CMD, v); chk("R10 cleared on launch", v, 32'h8000_0006);
    wait_idle(c);
    sb_check("R10 read after timeout");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule